// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

A 32-line general-purpose I/O bank controlled through a simple 32-bit register bus with a write strobe, a byte address and a combinational read path. Each line can be an input or an output. An output is either driven push-pull or driven low only, in open-drain style. An input reaches the data register only when its per-line input buffer is enabled.

Every pad input passes through a two-flop synchroniser and then an edge detector. Detected edges set sticky bits in an event register. Software clears these bits by writing ones. Each line can detect either both edges or only falling edges. The event bits are gated by a mask register, and any event that is both set and enabled raises a single interrupt line.

Registers are bit-reversed with respect to the lines. Line n is held in register bit 31−n, so line 0 is the most significant bit of every register. The pad-side vectors `pad_in`, `pad_oe` and `pad_out` are indexed by line number.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is all zeros and `irq` is low.
- R2: Line n corresponds to bit 31−n of every register. Pad vectors are indexed by line n.
- R3: The register word offsets are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge control 0x14 and input enable 0x18. A direction bit of 1 makes the line an output. For an output line whose open-drain bit is 0, `pad_oe` is 1 and `pad_out` equals the data bit. For an input line, `pad_oe` is 0.
- R4: For an output line whose open-drain bit is 1, `pad_out` is 0 and `pad_oe` is the inverse of the data bit.
- R5: Reading the data register returns the written data bit for output lines. For input lines it returns the synchronised pin value when the input enable bit is 1, and 0 when that bit is 0.
- R6: A pin change appears in a data-register read after exactly two rising clock edges, not earlier.
- R7: With edge-control bit 1, only falling edges set the event bit. With edge-control bit 0, both rising and falling edges set it.
- R8: An event bit becomes set on the third rising edge after the pin change. It then stays set until it is cleared.
- R9: Writing the event offset clears exactly the bits written as 1. Bits written as 0 keep their value.
- R10: When a new edge and a clearing write hit the same event bit on the same edge, the bit stays set.
- R11: `irq` is high exactly when some event bit and its mask bit are both 1.
- R12: Edge detection runs regardless of the line's direction or input enable bit.
- R13: Offset 0x1C reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Pin values, indexed by line |
| pad_oe | output | 32 | Pad output enable, indexed by line |
| pad_out | output | 32 | Pad output value, indexed by line |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a synchronised edge and a clearing write arriving at the same event bit on the same clock edge. The bench changes a pin at a falling clock edge and waits two more falling edges. It then asserts the clearing write for one cycle, so the write lands on the third rising edge, which is the edge where the event is captured. A behavioural model, updated on every clock edge, tracks the synchroniser stages per line. This lets the bench also check the two-edge read latency and the falling-only mode against a rise that immediately follows a fall.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int GPIO_W = 32;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = ADDR_W - 2;

  typedef enum logic [IDX_W-1:0] {
    RG_DIR  = 3'd0,
    RG_ODR  = 3'd1,
    RG_DAT  = 3'd2,
    RG_EVT  = 3'd3,
    RG_MSK  = 3'd4,
    RG_ECTL = 3'd5,
    RG_IBE  = 3'd6,
    RG_NONE = 3'd7
  } reg_idx_e;

  // Lines and register bits run in opposite order.
  function automatic logic [GPIO_W-1:0] swap_order(input logic [GPIO_W-1:0] v);
    logic [GPIO_W-1:0] r;
    for (int i = 0; i < GPIO_W; i++) r[GPIO_W-1-i] = v[i];
    return r;
  endfunction

  // Edge hits per bit: falling always counts, rising only when not fall-only.
  function automatic logic [GPIO_W-1:0] edge_hits(input logic [GPIO_W-1:0] cur,
                                                  input logic [GPIO_W-1:0] prev,
                                                  input logic [GPIO_W-1:0] fall_only);
    logic [GPIO_W-1:0] rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return fall | (rise & ~fall_only);
  endfunction

  // Data read: output latch for outputs, gated sample for inputs.
  function automatic logic [GPIO_W-1:0] data_view(input logic [GPIO_W-1:0] dir,
                                                  input logic [GPIO_W-1:0] dat,
                                                  input logic [GPIO_W-1:0] ibe,
                                                  input logic [GPIO_W-1:0] smp);
    return (dir & dat) | (~dir & ibe & smp);
  endfunction
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt
  import gpio_edge_pkg::*;
#(
  parameter int W = GPIO_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,        // synchronised pins, register bit order
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr,        // write-one-to-clear mask, one cycle
  input  logic [W-1:0] msk,
  output logic [W-1:0] evt,
  output logic [W-1:0] hit,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] evt_q;

  assign hit = edge_hits(smp, prev_q, fall_only);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= smp;
      evt_q  <= (evt_q & ~clr) | hit;
    end
  end

  assign evt = evt_q;
  assign irq = |(evt_q & msk);

  // R9: a cleared bit with no coinciding edge reads zero next cycle
  p_w1c_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~hit)) |=> ((evt & $past(clr & ~hit)) == '0));

  // R10: an edge always lands, even against a clearing write
  p_edge_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((evt & $past(hit)) == $past(hit)));

  // R8: set bits are lost only through a clearing write
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(evt) & ~$past(clr)) & ~evt) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int W  = GPIO_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic          irq
);
  localparam int IW = AW - 2;

  logic [W-1:0] dir_q, odr_q, dat_q, msk_q, ectl_q, ibe_q;
  logic [W-1:0] smp_line, smp_bit;
  logic [W-1:0] evt_bits, hit_bits, clr_bits;
  logic [W-1:0] oe_bits, out_bits;
  logic [IW-1:0] idx;
  logic         wr_evt, wr_msk;

  assign idx    = bus_addr[AW-1:2];
  assign wr_evt = bus_we && (idx == RG_EVT);
  assign wr_msk = bus_we && (idx == RG_MSK);
  assign clr_bits = wr_evt ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      odr_q  <= '0;
      dat_q  <= '0;
      msk_q  <= '0;
      ectl_q <= '0;
      ibe_q  <= '0;
    end else if (bus_we) begin
      case (idx)
        RG_DIR:  dir_q  <= bus_wdata;
        RG_ODR:  odr_q  <= bus_wdata;
        RG_DAT:  dat_q  <= bus_wdata;
        RG_MSK:  msk_q  <= bus_wdata;
        RG_ECTL: ectl_q <= bus_wdata;
        RG_IBE:  ibe_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  gpio_edge_sync #(.W(W), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (smp_line)
  );

  assign smp_bit = swap_order(smp_line);

  gpio_edge_evt #(.W(W)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .smp       (smp_bit),
    .fall_only (ectl_q),
    .clr       (clr_bits),
    .msk       (msk_q),
    .evt       (evt_bits),
    .hit       (hit_bits),
    .irq       (irq)
  );

  always_comb begin
    case (idx)
      RG_DIR:  bus_rdata = dir_q;
      RG_ODR:  bus_rdata = odr_q;
      RG_DAT:  bus_rdata = data_view(dir_q, dat_q, ibe_q, smp_bit);
      RG_EVT:  bus_rdata = evt_bits;
      RG_MSK:  bus_rdata = msk_q;
      RG_ECTL: bus_rdata = ectl_q;
      RG_IBE:  bus_rdata = ibe_q;
      default: bus_rdata = '0;
    endcase
  end

  // Push-pull drives the data bit; open-drain only ever pulls low.
  assign oe_bits  = dir_q & (~odr_q | ~dat_q);
  assign out_bits = dir_q & ~odr_q & dat_q;
  assign pad_oe   = swap_order(oe_bits);
  assign pad_out  = swap_order(out_bits);

  // R11: the interrupt drops only after a clear or a mask change
  p_irq_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(wr_evt || wr_msk));

  // R3: a line configured as input never has its pad enabled
  p_input_undriven_r3: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~swap_order(dir_q)) == '0);

  // R4: an enabled open-drain pad never drives high
  p_od_low_only_r4: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_out & swap_order(odr_q)) == '0);
endmodule

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_dir, m_odr, m_dat, m_evt, m_msk, m_ectl, m_ibe;
  logic [31:0] m_s1, m_s2, m_s3;   // per-line pin history

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] r;
    r = '0;
    case (a[4:2])
      3'd0: r = m_dir;
      3'd1: r = m_odr;
      3'd2: for (int n = 0; n < 32; n++)
              r[31-n] = m_dir[31-n] ? m_dat[31-n] : (m_ibe[31-n] & m_s2[n]);
      3'd3: r = m_evt;
      3'd4: r = m_msk;
      3'd5: r = m_ectl;
      3'd6: r = m_ibe;
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    logic [31:0] hitv, clr, eoe, eout;
    if (rst) begin
      m_dir = '0; m_odr = '0; m_dat = '0; m_evt = '0; m_msk = '0;
      m_ectl = '0; m_ibe = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
    end else begin
      hitv = '0;
      clr = '0;
      for (int n = 0; n < 32; n++)
        if (m_s2[n] != m_s3[n] && (!m_ectl[31-n] || m_s3[n]))
          hitv[31-n] = 1'b1;
      if (bus_we)
        case (bus_addr[4:2])
          3'd0: m_dir = bus_wdata;
          3'd1: m_odr = bus_wdata;
          3'd2: m_dat = bus_wdata;
          3'd3: clr = bus_wdata;
          3'd4: m_msk = bus_wdata;
          3'd5: m_ectl = bus_wdata;
          3'd6: m_ibe = bus_wdata;
          default: ;
        endcase
      m_evt = (m_evt & ~clr) | hitv;
      m_s3 = m_s2;
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
    #1;
    if (!rst && !finished) begin
      eoe = '0;
      eout = '0;
      for (int n = 0; n < 32; n++)
        if (m_dir[31-n]) begin
          if (m_odr[31-n]) eoe[n] = ~m_dat[31-n];
          else begin eoe[n] = 1'b1; eout[n] = m_dat[31-n]; end
        end
      chk(bus_addr[4:2] == 3'd3 ? "R8 model evt" : "R5 model rdata", bus_rdata, m_read(bus_addr));
      chk("R3 model pad_oe", pad_oe, eoe);
      chk("R4 model pad_out", pad_out, eout);
      chk("R11 model irq", {31'd0, irq}, {31'd0, |(m_evt & m_msk)});
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state, R13 unmapped slot
    for (int a = 0; a < 7; a++) rd(5'(a * 4), 32'h0, "R1 reset read");
    rd(5'h1C, 32'h0, "R13 unmapped read");
    chk("R1 pad_oe after reset", pad_oe, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);

    // R2, R3: lines 0..3 outputs, lines 0 and 2 high
    wr(5'h00, 32'hF000_0000);
    wr(5'h08, 32'hA000_0000);
    chk("R2 R3 pad_oe push-pull", pad_oe, 32'h0000_000F);
    chk("R2 R3 pad_out push-pull", pad_out, 32'h0000_0005);
    rd(5'h00, 32'hF000_0000, "R3 direction readback");

    // R4: lines 2,3 open-drain
    wr(5'h04, 32'h3000_0000);
    chk("R4 pad_oe open-drain", pad_oe, 32'h0000_000B);
    chk("R4 pad_out open-drain", pad_out, 32'h0000_0001);

    // R13: writes to unmapped slot ignored
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, 32'h0, "R13 unmapped after write");
    rd(5'h00, 32'hF000_0000, "R13 dir untouched");
    rd(5'h18, 32'h0, "R13 ibe untouched");

    // R5, R6, R12: inputs on lines 16 (enabled) and 8 (disabled)
    wr(5'h18, 32'h0000_FFFF);
    @(negedge clk);
    pad_in = 32'h0001_0100;
    bus_addr = 5'h08;
    #1 chk("R6 no change before first edge", bus_rdata, 32'hA000_0000);
    @(negedge clk);
    #1 chk("R6 no change after one edge", bus_rdata, 32'hA000_0000);
    @(negedge clk);
    #1 chk("R5 R6 data after two edges", bus_rdata, 32'hA000_8000);
    rd(5'h0C, 32'h0080_8000, "R8 R12 events on both rising lines");
    chk("R11 irq low while masked", {31'd0, irq}, 32'h0);

    // R11, R9
    wr(5'h10, 32'h0000_8000);
    chk("R11 irq after unmask", {31'd0, irq}, 32'h1);
    wr(5'h0C, 32'h0000_8000);
    rd(5'h0C, 32'h0080_0000, "R9 only written bit cleared");
    chk("R11 irq after clear", {31'd0, irq}, 32'h0);

    // R7: line 8 falling-only, line 16 both edges
    wr(5'h14, 32'h0080_0000);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, 32'h0, "R9 clear all");
    @(negedge clk) pad_in = 32'h0001_0000;
    idle(4);
    rd(5'h0C, 32'h0080_0000, "R7 falling edge flagged");
    wr(5'h0C, 32'hFFFF_FFFF);
    @(negedge clk) pad_in = 32'h0001_0100;
    idle(4);
    rd(5'h0C, 32'h0, "R7 rising ignored in falling-only mode");
    @(negedge clk) pad_in = 32'h0000_0100;
    idle(4);
    rd(5'h0C, 32'h0000_8000, "R7 falling flagged in both-edge mode");
    chk("R11 irq on masked event", {31'd0, irq}, 32'h1);

    // R10: clearing write lands on the capture edge
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, 32'h0, "R10 precondition cleared");
    @(negedge clk) pad_in = 32'h0001_0100;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h0000_8000;
    @(negedge clk);
    bus_we = 1'b0;
    #1 chk("R10 edge beats clear", bus_rdata, 32'h0000_8000);

    idle(3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule